// File: doc/BRIEF.md
# Hybrid Sector Map Erase Checker

This block sits between a serial flash command decoder and the erase engine of a 64-Mbyte array. Each cycle it may take one erase request, made of a command code and a byte address. It works out which physical sector the request lands in and whether the array can honour that erase granularity there. One cycle later it reports the result: the sector start address, the sector size in bytes, and an accept flag.

Two configuration inputs select the sector layout. In the uniform layout the whole array is cut into 256-kbyte blocks. In the hybrid layout, one 256-kbyte block at the lowest or the highest end of the array is split differently. It holds eight 4-kbyte parameter sectors and one 224-kbyte sector, and the 224-kbyte sector sits on the side of the block that faces the rest of the array. A further input selects 24-bit or 32-bit addressing.

Top module: `erase_map_check`

## Requirements
- R1: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and low in every other cycle. All response outputs come from registers.
- R2: While `rstN` is low, `rspValid`, `rspAccept`, `rspStart` and `rspSize` are all zero.
- R3: When `addr32Mode` is 0, bits 31:24 of `reqAddr` are ignored and taken as zero. When `addr32Mode` is 1, any address at or above 0x0400_0000 is rejected for every command.
- R4: The command codes are 3'd0 for a 4-kbyte erase, 3'd1 for a 256-kbyte block erase, 3'd2 for an 8-kbyte erase, 3'd3 for a 32-kbyte erase and 3'd4 for a 64-kbyte erase. Codes 3'd5 to 3'd7 are undefined. Only codes 3'd0 and 3'd1 can ever be accepted.
- R5: With `hybridEn` = 0, a block erase on an in-range address is accepted, with start equal to the address with bits 17:0 cleared and size 0x40000.
- R6: With `hybridEn` = 0, every 4-kbyte erase is rejected.
- R7: With `hybridEn` = 1 and `paramTop` = 0, a 4-kbyte erase is accepted for addresses 0x0 to 0x7FFF, with start equal to the address with bits 11:0 cleared and size 0x1000. It is rejected for any address at or above 0x8000.
- R8: With `hybridEn` = 1 and `paramTop` = 0, a block erase on an address below 0x40000 is accepted with start 0x8000 and size 0x38000, including addresses inside the parameter sectors. Block erases at or above 0x40000 behave as in R5.
- R9: With `hybridEn` = 1 and `paramTop` = 1, the layout is mirrored. A 4-kbyte erase is accepted only for 0x3FF_8000 to 0x3FF_FFFF. A block erase on 0x3FC_0000 to 0x3FF_FFFF reports start 0x3FC_0000 and size 0x38000, and other block erases behave as in R5.
- R10: A rejected request reports `rspStart` = 0 and `rspSize` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqCmd | input | 3 | Erase command code (R4) |
| reqAddr | input | 32 | Byte address of the request |
| addr32Mode | input | 1 | 1: 32-bit address, 0: 24-bit address |
| hybridEn | input | 1 | 1: hybrid layout, 0: uniform layout |
| paramTop | input | 1 | Hybrid block at the top (1) or the bottom (0) |
| rspValid | output | 1 | Result present this cycle |
| rspAccept | output | 1 | Erase accepted |
| rspStart | output | 32 | Start address of the addressed sector |
| rspSize | output | 19 | Size of the addressed sector in bytes |

## Verification
Every result is due on the clock edge that follows the request, so each response field has exactly one cycle of latency. The driver presents each request just after a falling edge and pushes the expected result, computed from the requirements, into a queue. The monitor samples one nanosecond after each rising edge. A non-empty queue there means a result must be present and is compared. An empty queue means `rspValid` must be low, which also covers the gaps between bursts of back-to-back requests.

// File: rtl/erase_map_pkg.sv
package erase_map_pkg;

  typedef enum logic [2:0] {
    ERS_SMALL = 3'd0,
    ERS_BLOCK = 3'd1,
    ERS_PAIR  = 3'd2,
    ERS_GROUP = 3'd3,
    ERS_MID   = 3'd4
  } eraseCmd_e;

  // where the normalised address falls
  typedef struct packed {
    logic inRange;
    logic inHybridBlock;
    logic inParam;
  } regionFlags_t;

  // control -> datapath strobes, exactly one set per request
  typedef struct packed {
    logic selSmall;
    logic selHybrid;
    logic selBlock;
    logic selReject;
  } sectorSel_t;

endpackage

// File: rtl/erase_map_ctrl.sv
module erase_map_ctrl
  import erase_map_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [2:0]   reqCmd,
  input  logic         hybridEn,
  input  regionFlags_t flags,
  output sectorSel_t   sel
);

  always_comb begin
    sel = '0;
    unique case (reqCmd)
      ERS_SMALL: begin
        if (hybridEn && flags.inRange && flags.inParam) sel.selSmall = 1'b1;
        else                                            sel.selReject = 1'b1;
      end
      ERS_BLOCK: begin
        if (!flags.inRange)                      sel.selReject = 1'b1;
        else if (hybridEn && flags.inHybridBlock) sel.selHybrid = 1'b1;
        else                                      sel.selBlock  = 1'b1;
      end
      default: sel.selReject = 1'b1;
    endcase
  end

  // R4: exactly one decision per request
  a_r4_one_decision: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones(sel) == 1);

  // R6: small-sector acceptance only in the hybrid layout
  a_r6_small_needs_hybrid: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && sel.selSmall) |-> hybridEn);

  // R4: only the two legal codes can be accepted
  a_r4_legal_codes: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !sel.selReject) |-> (reqCmd == 3'd0 || reqCmd == 3'd1));

endmodule

// File: rtl/erase_map_dp.sv
module erase_map_dp
  import erase_map_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NARROW_W    = 24,
  parameter int ARRAY_AW    = 26,
  parameter int BIG_AW      = 18,
  parameter int SMALL_AW    = 12,
  parameter int PARAM_COUNT = 8,
  parameter int SIZE_W      = BIG_AW + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              addr32Mode,
  input  logic              paramTop,
  input  sectorSel_t        sel,
  output regionFlags_t      flags,
  output logic              rspValid,
  output logic              rspAccept,
  output logic [ADDR_W-1:0] rspStart,
  output logic [SIZE_W-1:0] rspSize
);

  localparam int BLK_IDX_W = ARRAY_AW - BIG_AW;
  localparam logic [BIG_AW-1:0] PARAM_BYTES =
    BIG_AW'(64'(PARAM_COUNT) << SMALL_AW);
  localparam logic [BIG_AW-1:0] HYB_OFFSET_TOP =
    BIG_AW'((64'd1 << BIG_AW) - (64'(PARAM_COUNT) << SMALL_AW));
  localparam logic [ADDR_W-1:0] TOP_BLOCK_START =
    ADDR_W'((64'd1 << ARRAY_AW) - (64'd1 << BIG_AW));
  localparam logic [SIZE_W-1:0] SMALL_SIZE = SIZE_W'(64'd1 << SMALL_AW);
  localparam logic [SIZE_W-1:0] BIG_SIZE   = SIZE_W'(64'd1 << BIG_AW);
  localparam logic [SIZE_W-1:0] HYB_SIZE   =
    SIZE_W'((64'd1 << BIG_AW) - (64'(PARAM_COUNT) << SMALL_AW));

  logic [ADDR_W-1:0]    normAddr;
  logic [BLK_IDX_W-1:0] blockIdx;
  logic [BIG_AW-1:0]    blockOffset;
  logic                 inRange;

  always_comb begin
    normAddr = reqAddr;
    if (!addr32Mode) normAddr[ADDR_W-1:NARROW_W] = '0;
  end

  generate
    if (ARRAY_AW < ADDR_W) begin : g_range
      assign inRange = (normAddr[ADDR_W-1:ARRAY_AW] == '0);
    end else begin : g_full
      assign inRange = 1'b1;
    end
  endgenerate

  assign blockIdx    = normAddr[ARRAY_AW-1:BIG_AW];
  assign blockOffset = normAddr[BIG_AW-1:0];

  always_comb begin
    flags.inRange       = inRange;
    flags.inHybridBlock = paramTop ? (blockIdx == '1) : (blockIdx == '0);
    flags.inParam       = flags.inHybridBlock &&
                          (paramTop ? (blockOffset >= HYB_OFFSET_TOP)
                                    : (blockOffset <  PARAM_BYTES));
  end

  logic [ADDR_W-1:0] nextStart;
  logic [SIZE_W-1:0] nextSize;

  always_comb begin
    nextStart = '0;
    nextSize  = '0;
    if (sel.selSmall) begin
      nextStart = {normAddr[ADDR_W-1:SMALL_AW], SMALL_AW'(0)};
      nextSize  = SMALL_SIZE;
    end else if (sel.selHybrid) begin
      nextStart = paramTop ? TOP_BLOCK_START : ADDR_W'(PARAM_BYTES);
      nextSize  = HYB_SIZE;
    end else if (sel.selBlock) begin
      nextStart = {normAddr[ADDR_W-1:BIG_AW], BIG_AW'(0)};
      nextSize  = BIG_SIZE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspAccept <= 1'b0;
      rspStart  <= '0;
      rspSize   <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspAccept <= !sel.selReject;
        rspStart  <= nextStart;
        rspSize   <= nextSize;
      end
    end
  end

  // R1: one result per request, one cycle later
  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R10: rejected results carry no sector
  a_r10_reject_empty: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAccept) |-> (rspStart == '0 && rspSize == '0));

  // R5: block results are block aligned
  a_r5_block_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAccept && rspSize == BIG_SIZE) |-> (rspStart[BIG_AW-1:0] == '0));

  // R3: accepted sectors lie within the array
  a_r3_inside_array: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAccept) |-> ({1'b0, rspStart} < (33'd1 << ARRAY_AW)));

endmodule

// File: rtl/erase_map_check.sv
module erase_map_check
  import erase_map_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NARROW_W    = 24,
  parameter int ARRAY_AW    = 26,
  parameter int BIG_AW      = 18,
  parameter int SMALL_AW    = 12,
  parameter int PARAM_COUNT = 8,
  parameter int SIZE_W      = BIG_AW + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              addr32Mode,
  input  logic              hybridEn,
  input  logic              paramTop,
  output logic              rspValid,
  output logic              rspAccept,
  output logic [ADDR_W-1:0] rspStart,
  output logic [SIZE_W-1:0] rspSize
);

  regionFlags_t flags;
  sectorSel_t   sel;

  erase_map_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqCmd   (reqCmd),
    .hybridEn (hybridEn),
    .flags    (flags),
    .sel      (sel)
  );

  erase_map_dp #(
    .ADDR_W      (ADDR_W),
    .NARROW_W    (NARROW_W),
    .ARRAY_AW    (ARRAY_AW),
    .BIG_AW      (BIG_AW),
    .SMALL_AW    (SMALL_AW),
    .PARAM_COUNT (PARAM_COUNT),
    .SIZE_W      (SIZE_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqAddr    (reqAddr),
    .addr32Mode (addr32Mode),
    .paramTop   (paramTop),
    .sel        (sel),
    .flags      (flags),
    .rspValid   (rspValid),
    .rspAccept  (rspAccept),
    .rspStart   (rspStart),
    .rspSize    (rspSize)
  );

  // R7: small-sector results only in the hybrid layout
  a_r7_small_hybrid_only: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspAccept && rspSize == SIZE_W'(64'd1 << SMALL_AW)) |-> $past(hybridEn));

endmodule

// File: tb/test_erase_map_check.sv
module test_erase_map_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqCmd = 3'd0;
  logic [31:0] reqAddr = '0;
  logic        addr32Mode = 1'b0;
  logic        hybridEn = 1'b0;
  logic        paramTop = 1'b0;
  logic        rspValid, rspAccept;
  logic [31:0] rspStart;
  logic [18:0] rspSize;

  always #4 clk = ~clk;

  erase_map_check i_erase_map_check (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .addr32Mode(addr32Mode), .hybridEn(hybridEn),
    .paramTop(paramTop), .rspValid(rspValid), .rspAccept(rspAccept),
    .rspStart(rspStart), .rspSize(rspSize)
  );

  typedef struct {
    logic        acc;
    logic [31:0] st;
    logic [18:0] sz;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 0;

  function automatic exp_t model(logic [2:0] cmd, logic [31:0] addr, logic a32,
                                 logic hyb, logic top, string tag);
    exp_t e;
    logic [31:0] a;
    a = a32 ? addr : {8'h00, addr[23:0]};
    e.acc = 0; e.st = 0; e.sz = 0; e.tag = tag;
    if (a >= 32'h0400_0000) return e;
    if (cmd == 3'd0) begin
      if (hyb && (top ? (a >= 32'h03FF_8000) : (a < 32'h0000_8000))) begin
        e.acc = 1; e.st = a & ~32'hFFF; e.sz = 19'h1000;
      end
    end else if (cmd == 3'd1) begin
      e.acc = 1;
      if (hyb && (top ? (a >= 32'h03FC_0000) : (a < 32'h0004_0000))) begin
        e.st = top ? 32'h03FC_0000 : 32'h0000_8000; e.sz = 19'h38000;
      end else begin
        e.st = a & ~32'h3FFFF; e.sz = 19'h40000;
      end
    end
    return e;
  endfunction

  task automatic issue(logic [2:0] cmd, logic [31:0] addr, logic a32,
                       logic hyb, logic top, string tag);
    @(negedge clk);
    reqValid = 1; reqCmd = cmd; reqAddr = addr;
    addr32Mode = a32; hybridEn = hyb; paramTop = top;
    expQ.push_back(model(cmd, addr, a32, hyb, top, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 0;
      reqAddr  = 32'hDEAD_BEEF;
    end
  endtask

  task automatic check(bit ok, string msg, logic [63:0] act, logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", msg, act, expv);
    end
  endtask

  // monitor: compares results one cycle after each request
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (expQ.size() > 0) begin
          exp_t e;
          e = expQ.pop_front();
          check(rspValid == 1, {"R1 result missing ", e.tag}, 64'(rspValid), 64'd1);
          if (rspValid) begin
            check(rspAccept == e.acc, {e.tag, " accept"}, 64'(rspAccept), 64'(e.acc));
            check(rspStart == e.st, {e.tag, " start"}, 64'(rspStart), 64'(e.st));
            check(rspSize == e.sz, {e.tag, " size"}, 64'(rspSize), 64'(e.sz));
          end
        end else begin
          check(rspValid == 0, "R1 spurious result", 64'(rspValid), 64'd0);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(rspValid == 0, "R2 valid in reset", 64'(rspValid), 0);
    check(rspAccept == 0, "R2 accept in reset", 64'(rspAccept), 0);
    check(rspStart == 0, "R2 start in reset", 64'(rspStart), 0);
    check(rspSize == 0, "R2 size in reset", 64'(rspSize), 0);
    rstN = 1;
    idle(2);

    // R5 uniform block erase, back to back (R1)
    issue(3'd1, 32'h0012_3456, 0, 0, 0, "R5 uniform 24b");
    issue(3'd1, 32'h03AB_CDEF, 1, 0, 0, "R5 uniform 32b");
    issue(3'd1, 32'h0000_0000, 1, 0, 0, "R5 uniform zero");
    idle(1);
    // R3 addressing
    issue(3'd1, 32'hAB12_3456, 0, 0, 0, "R3 upper byte ignored");
    issue(3'd1, 32'h0400_0000, 1, 0, 0, "R3 out of range block");
    issue(3'd0, 32'hFFFF_F000, 1, 1, 1, "R3 out of range small");
    issue(3'd1, 32'hFFFF_FFFF, 0, 0, 0, "R3 24b max");
    idle(2);
    // R6 uniform small erase rejected
    issue(3'd0, 32'h0000_0000, 1, 0, 0, "R6 uniform small low");
    issue(3'd0, 32'h03FF_F000, 1, 0, 1, "R6 uniform small high");
    // R4 unsupported codes
    issue(3'd2, 32'h0000_0000, 1, 1, 0, "R4 8k code");
    issue(3'd3, 32'h0000_1000, 1, 1, 0, "R4 32k code");
    issue(3'd4, 32'h0010_0000, 1, 0, 0, "R4 64k code");
    issue(3'd7, 32'h0010_0000, 1, 0, 0, "R4 undefined code");
    idle(1);
    // R7 hybrid bottom small sectors
    issue(3'd0, 32'h0000_0000, 1, 1, 0, "R7 first small");
    issue(3'd0, 32'h0000_7FFF, 1, 1, 0, "R7 last small");
    issue(3'd0, 32'h0000_3ABC, 0, 1, 0, "R7 mid small");
    issue(3'd0, 32'h0000_8000, 1, 1, 0, "R7 just past small");
    issue(3'd0, 32'h0100_0000, 1, 1, 0, "R7 far small");
    // R8 hybrid bottom block erase
    issue(3'd1, 32'h0000_0100, 1, 1, 0, "R8 block in param");
    issue(3'd1, 32'h0000_8000, 1, 1, 0, "R8 block hybrid start");
    issue(3'd1, 32'h0003_FFFF, 1, 1, 0, "R8 block hybrid end");
    issue(3'd1, 32'h0004_0000, 1, 1, 0, "R8 next uniform block");
    idle(3);
    // R9 hybrid top
    issue(3'd0, 32'h03FF_8000, 1, 1, 1, "R9 first top small");
    issue(3'd0, 32'h03FF_FFFF, 1, 1, 1, "R9 last top small");
    issue(3'd0, 32'h03FF_7FFF, 1, 1, 1, "R9 below top small");
    issue(3'd0, 32'h0000_0000, 1, 1, 1, "R9 bottom small in top mode");
    issue(3'd1, 32'h03FC_0000, 1, 1, 1, "R9 block hybrid start");
    issue(3'd1, 32'h03FF_C000, 1, 1, 1, "R9 block in top param");
    issue(3'd1, 32'h03FB_FFFF, 1, 1, 1, "R9 block below hybrid");
    issue(3'd1, 32'h0000_0000, 1, 1, 1, "R9 bottom block uniform");
    issue(3'd0, 32'hFFFF_F000, 0, 1, 1, "R9 24b cannot reach top");
    // R10 rejection after an accept keeps fields clear
    issue(3'd1, 32'h0200_0000, 1, 0, 0, "R10 accept before reject");
    issue(3'd0, 32'h0200_0000, 1, 0, 0, "R10 reject clears fields");
    idle(4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule